// File: doc/BRIEF.md
# I2C Master Bit-Clock Generator

This block produces the bit timing for an I2C master controller. A host writes a 7-bit clock setting made of a power-of-two exponent and a linear scalar. The first stage divides the system clock by 2^N to make a sampling strobe. The second stage counts those strobes in groups of (M+1) to form phase steps. Ten steps make one SCL period: five with SCL low, then five with SCL high.

The controller that drives the bus lines uses three outputs. The sampling strobe is one of them. The second is a level that says whether SCL should currently be low or high. The third is a setup tick that fires inside each low half, where the next data bit may be placed on SDA.

A new setting is held pending and takes effect only where one period ends and the next begins, so no phase is ever cut short. Reset leaves the generator in the idle-high state with the fastest setting. From there it free-runs.

Top module: `i2c_clkgen`

## Requirements
- R1: The control word `ctl_wdata` carries the exponent N in bits 2:0 and the scalar M in bits 6:3.
- R2: With exponent N active, `samp_tick` is high once every 2^N system clock cycles.
- R3: For N of 1 or more, `samp_tick` is a single-cycle pulse, low in the cycle after each pulse.
- R4: `scl_high` stays low for 5*(M+1)*2^N cycles and then high for 5*(M+1)*2^N cycles, so a full SCL period lasts 10*(M+1)*2^N cycles.
- R5: `scl_high` changes only on a phase step, which comes every (M+1) sampling strobes, and it toggles after every five steps.
- R6: `qtr_tick` pulses for exactly one cycle per period, during the low half, 2*(M+1)*2^N cycles after `scl_high` falls, and never during the high half.
- R7: A setting written with `ctl_we` takes effect at the next falling edge of `scl_high`. The phases already under way finish with the previous setting.
- R8: Reset selects N=0 and M=0 and holds `scl_high` at 1 with `qtr_tick` at 0. `scl_high` falls in the first cycle after reset is released.
- R9: When several writes arrive before a period boundary, only the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the clock setting |
| ctl_wdata | input | 7 | Clock setting: M in bits 6:3, N in bits 2:0 |
| samp_tick | output | 1 | Sampling strobe, once every 2^N cycles |
| scl_high | output | 1 | SCL phase: 1 = high half or idle, 0 = low half |
| qtr_tick | output | 1 | One-cycle data-setup tick inside the low half |

## Verification
If the exponent counter is wrong, the spacing of `samp_tick` changes at once. Every later phase length is then scaled by the same factor within one period. If the step counter is wrong, a low or high half comes out with something other than five steps, or the setup tick moves or repeats. This shows at the next `scl_high` edge. If a setting is applied early, the half-period that was under way when the write landed gets the wrong length. If a setting is lost, the period after the boundary has the wrong length. The checks therefore measure every half-phase and the setup offset, in system clock cycles, around each write.

// File: rtl/i2c_clkgen_pkg.sv
package i2c_clkgen_pkg;

  localparam int CFG_EXP_W = 3;
  localparam int CFG_SCL_W = 4;
  localparam int CFG_W     = CFG_EXP_W + CFG_SCL_W;
  localparam int PRE_W     = (1 << CFG_EXP_W) - 1;

  // Scalar sits above the exponent: bits 6:3 = M, bits 2:0 = N
  typedef struct packed {
    logic [CFG_SCL_W-1:0] m;
    logic [CFG_EXP_W-1:0] n;
  } clk_cfg_t;

  // Terminal count of the exponent stage: 2^n - 1 as a thermometer mask
  function automatic logic [PRE_W-1:0] exp_limit(input logic [CFG_EXP_W-1:0] n);
    logic [PRE_W-1:0] r;
    for (int i = 0; i < PRE_W; i++) r[i] = (i < int'(n));
    return r;
  endfunction

  // Cycles in one half of an SCL period
  function automatic int unsigned half_cycles(input int unsigned half_steps,
                                              input clk_cfg_t cfg);
    return half_steps * (int'(cfg.m) + 1) * (1 << cfg.n);
  endfunction

endpackage

// File: rtl/clkgen_cfg.sv
module clkgen_cfg
  import i2c_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             apply,
  output clk_cfg_t         active
);

  clk_cfg_t pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (wr_en) pending <= clk_cfg_t'(wr_data);
      if (apply) active  <= pending;
    end
  end

endmodule

// File: rtl/clkgen_expdiv.sv
module clkgen_expdiv
  import i2c_clkgen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_EXP_W-1:0] n,
  output logic                 samp_tick
);

  logic [PRE_W-1:0] pre_cnt;

  assign samp_tick = (pre_cnt == exp_limit(n));

  always_ff @(posedge clk) begin
    if (!rst_n)         pre_cnt <= '0;
    else if (samp_tick) pre_cnt <= '0;
    else                pre_cnt <= pre_cnt + 1'b1;
  end

endmodule

// File: rtl/clkgen_lindiv.sv
module clkgen_lindiv
  import i2c_clkgen_pkg::*;
#(
  parameter int HALF_STEPS = 5,
  parameter int SETUP_STEP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 samp_tick,
  input  logic [CFG_SCL_W-1:0] m,
  output logic                 step_evt,
  output logic                 period_bnd,
  output logic                 scl_high,
  output logic                 qtr_tick
);

  localparam int STEP_W = $clog2(2 * HALF_STEPS);
  localparam logic [STEP_W-1:0] LAST_ST  = STEP_W'(2 * HALF_STEPS - 1);
  localparam logic [STEP_W-1:0] HALF_ST  = STEP_W'(HALF_STEPS);
  localparam logic [STEP_W-1:0] SETUP_ST = STEP_W'(SETUP_STEP);

  logic [CFG_SCL_W-1:0] lin_cnt;
  logic [STEP_W-1:0]    st, st_nx;

  assign step_evt   = samp_tick && (lin_cnt == m);
  assign period_bnd = step_evt && (st == LAST_ST);
  assign st_nx      = (st == LAST_ST) ? '0 : st + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_cnt  <= '0;
      st       <= LAST_ST;
      scl_high <= 1'b1;
      qtr_tick <= 1'b0;
    end else begin
      qtr_tick <= step_evt && (st_nx == SETUP_ST);
      if (step_evt) begin
        lin_cnt  <= '0;
        st       <= st_nx;
        scl_high <= (st_nx >= HALF_ST);
      end else if (samp_tick) begin
        lin_cnt <= lin_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_clkgen.sv
module i2c_clkgen
  import i2c_clkgen_pkg::*;
#(
  parameter int HALF_STEPS = 5,
  parameter int SETUP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CFG_W-1:0] ctl_wdata,
  output logic             samp_tick,
  output logic             scl_high,
  output logic             qtr_tick
);

  clk_cfg_t act_cfg;
  logic     step_evt;
  logic     period_bnd;

  clkgen_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .apply   (period_bnd),
    .active  (act_cfg)
  );

  clkgen_expdiv u_exp (
    .clk       (clk),
    .rst_n     (rst_n),
    .n         (act_cfg.n),
    .samp_tick (samp_tick)
  );

  clkgen_lindiv #(
    .HALF_STEPS (HALF_STEPS),
    .SETUP_STEP (SETUP_STEP)
  ) u_lin (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_tick  (samp_tick),
    .m          (act_cfg.m),
    .step_evt   (step_evt),
    .period_bnd (period_bnd),
    .scl_high   (scl_high),
    .qtr_tick   (qtr_tick)
  );

endmodule

// File: rtl/i2c_clkgen_chk.sv
module i2c_clkgen_chk
  import i2c_clkgen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             samp_tick,
  input logic             scl_high,
  input logic             qtr_tick,
  input logic             step_evt,
  input logic             period_bnd,
  input logic [CFG_W-1:0] act_cfg
);

  a_r3_samp_single: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && (act_cfg[CFG_EXP_W-1:0] != '0) && !period_bnd) |=> !samp_tick);

  a_r5_phase_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(scl_high));

  a_r6_qtr_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |-> !scl_high);

  a_r6_qtr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_tick |=> !qtr_tick);

  a_r7_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !period_bnd |=> $stable(act_cfg));

endmodule

bind i2c_clkgen i2c_clkgen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_tick  (samp_tick),
  .scl_high   (scl_high),
  .qtr_tick   (qtr_tick),
  .step_evt   (step_evt),
  .period_bnd (period_bnd),
  .act_cfg    (act_cfg)
);

// File: tb/tb_i2c_clkgen.sv
module tb_i2c_clkgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic       samp_tick, scl_high, qtr_tick;
  int         checks = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  i2c_clkgen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .samp_tick (samp_tick),
    .scl_high  (scl_high),
    .qtr_tick  (qtr_tick)
  );

  function automatic int half_len(input int n, input int m);
    return 5 * (m + 1) * (1 << n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int n, input int m);
    @(negedge clk);
    ctl_wdata = {4'(m), 3'(n)};
    ctl_we    = 1'b1;
    @(negedge clk);
    ctl_we    = 1'b0;
  endtask

  // Measure one phase at level lvl. fresh=1: the current negedge is its first sample.
  task automatic meas_phase(input bit lvl, input bit fresh,
                            output int len, output int qpos, output int qn);
    if (!fresh) begin
      while (scl_high == lvl) @(negedge clk);
      while (scl_high != lvl) @(negedge clk);
    end
    len = 0; qpos = -1; qn = 0;
    while (scl_high == lvl) begin
      if (qtr_tick) begin qn++; qpos = len; end
      @(negedge clk);
      len++;
    end
  endtask

  task automatic t_reset();
    int lo, hi, qp, qn;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_high == 1'b1, "R8 idle high in reset", int'(scl_high), 1);
    chk(qtr_tick == 1'b0, "R8 no setup tick in reset", int'(qtr_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_high == 1'b0, "R8 falls first cycle after reset", int'(scl_high), 0);
    meas_phase(1'b0, 1'b1, lo, qp, qn);
    chk(lo == half_len(0, 0), "R8 default low length", lo, half_len(0, 0));
    meas_phase(1'b1, 1'b1, hi, qp, qn);
    chk(hi == half_len(0, 0), "R8 default high length", hi, half_len(0, 0));
  endtask

  task automatic t_timing(input int n, input int m);
    int lo, hi, qp, qn, hqp, hqn, gap;
    wr_cfg(n, m);
    meas_phase(1'b0, 1'b0, lo, qp, qn);
    meas_phase(1'b1, 1'b1, hi, hqp, hqn);
    chk(lo == half_len(n, m), "R4/R1 low length", lo, half_len(n, m));
    chk(hi == half_len(n, m), "R4/R1 high length", hi, half_len(n, m));
    chk(qp == 2 * (m + 1) * (1 << n), "R6 setup tick offset", qp, 2 * (m + 1) * (1 << n));
    chk(qn == 1, "R6 one setup tick in low half", qn, 1);
    chk(hqn == 0, "R6 no setup tick in high half", hqn, 0);
    while (!samp_tick) @(negedge clk);
    @(negedge clk);
    if (n > 0) chk(samp_tick == 1'b0, "R3 sample tick single cycle", int'(samp_tick), 0);
    gap = 1;
    while (!samp_tick) begin @(negedge clk); gap++; end
    chk(gap == (1 << n), "R2 sample tick spacing", gap, 1 << n);
  endtask

  task automatic t_midchange(input int na, input int ma, input int nb, input int mb);
    int lo, hi, qp, qn;
    wr_cfg(na, ma);
    meas_phase(1'b0, 1'b0, lo, qp, qn);
    while (scl_high) @(negedge clk);
    wr_cfg(nb, mb);
    meas_phase(1'b1, 1'b0, hi, qp, qn);
    chk(hi == half_len(na, ma), "R7 old setting finishes high half", hi, half_len(na, ma));
    meas_phase(1'b0, 1'b1, lo, qp, qn);
    chk(lo == half_len(nb, mb), "R7 new setting from boundary", lo, half_len(nb, mb));
  endtask

  task automatic t_last_write(input int na, input int ma, input int nb, input int mb);
    int lo, hi, qp, qn;
    while (scl_high) @(negedge clk);
    wr_cfg(na, ma);
    wr_cfg(nb, mb);
    meas_phase(1'b0, 1'b0, lo, qp, qn);
    chk(lo == half_len(nb, mb), "R9 last write wins low", lo, half_len(nb, mb));
    meas_phase(1'b1, 1'b1, hi, qp, qn);
    chk(hi == half_len(nb, mb), "R9 last write wins high", hi, half_len(nb, mb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_timing(0, 0);
    t_timing(1, 2);
    t_timing(3, 0);
    t_timing(2, 5);
    t_timing(0, 15);
    t_midchange(0, 1, 2, 0);
    t_midchange(1, 0, 0, 3);
    t_last_write(2, 2, 1, 4);
    t_timing(7, 15);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule